// File: doc/BRIEF.md
# Message RAM with single-correct, double-detect protection

This block is a word-addressed 2 KB message store. It protects every 32-bit word with seven check bits. Six of them are Hamming bits, and the seventh is an overall parity bit over the word and those six bits. The check bits are produced on each write and kept beside the data.

On a read, the stored codeword is decoded. A single flipped bit, in the data or in the check bits, is corrected on the way out. Two flipped bits are reported and not corrected. The memory itself is never rewritten by a read. Each detected event latches a sticky flag, one for corrected errors and one for uncorrectable errors. It also records the byte address of the failing word. Each flag has its own enable, and the two feed a single interrupt line.

A global ECC switch bypasses the decoder, so raw stored words can be read. While the switch is off, writes store check bits supplied by the caller instead of computed ones. Software uses this to place known-bad codewords for diagnostics.

Top module: `msgram_secded`

## Requirements
- R1: A read request (req_valid=1, req_write=0) sampled at a clock edge makes rd_valid high for exactly the following cycle, with rd_data valid in that cycle. A write request never raises rd_valid.
- R2: A word written with ecc_en=1 and later read with ecc_en=1 returns the written data and raises no flag.
- R3: With ecc_en=1, a write stores check bits defined as follows. The 32 data bits occupy, in ascending bit order, codeword positions 1..38 that are not powers of two. Check bit j (j=0..5) is the even parity of the data bits whose position has bit j set. Check bit 6 is the even parity of all 32 data bits and check bits 0..5.
- R4: When a read finds exactly one data bit flipped and ecc_en was 1 at the request, rd_data is the corrected word. sec_flag rises at the edge that ends the rd_valid cycle. The stored word is left unchanged, so a later read with ecc_en=0 still returns the flipped bit.
- R5: A single flipped check bit, including check bit 6, leaves rd_data equal to the stored data and sets sec_flag.
- R6: Two flipped bits (even overall parity with a nonzero syndrome), or odd parity with a syndrome above 38, set ded_flag, leave sec_flag untouched, and return the stored data bits unmodified.
- R7: On every corrected or uncorrectable event, err_addr takes the byte address of the word (word address times 4) in 12 bits. Otherwise err_addr holds its value.
- R8: A read requested with ecc_en=0 returns the raw stored data and sets no flag. A write with ecc_en=0 stores parity_in as the seven check bits.
- R9: Each flag stays set until a cycle with its clear bit high: flag_clr[0] clears sec_flag and flag_clr[1] clears ded_flag. A new event at the same edge wins over the clear.
- R10: irq is high exactly when (sec_flag and sec_ie) or (ded_flag and ded_ie).
- R11: After reset, rd_valid, sec_flag, ded_flag and irq are 0 and err_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Word address |
| req_wdata | input | 32 | Write data |
| parity_in | input | 7 | Check bits stored by writes while ECC is off |
| ecc_en | input | 1 | Global correction/detection enable |
| sec_ie | input | 1 | Interrupt enable for corrected errors |
| ded_ie | input | 1 | Interrupt enable for uncorrectable errors |
| flag_clr | input | 2 | Write-one-to-clear strobes: bit0 corrected, bit1 uncorrectable |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, corrected when ECC was on |
| sec_flag | output | 1 | Sticky corrected-error flag |
| ded_flag | output | 1 | Sticky uncorrectable-error flag |
| err_addr | output | 12 | Byte address of the last failing word |
| irq | output | 1 | Interrupt |

## Verification
The hardest condition to reach from the ports is a stored codeword that disagrees with its own check bits, because a normal write always stores a consistent word. The stimulus gets there by writing with ECC off. The data carries chosen bit flips, and parity_in is computed in the bench for the unflipped word. ECC is then switched on for the read. Sweeps walk the flip across every data and check position and across pairs. Clear strobes land on the exact edge where a new event arrives, to exercise the priority of a set over a clear.

// File: rtl/msgram_pkg.sv
package msgram_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SYN_W  = 6;
    localparam int unsigned CHK_W  = SYN_W + 1;
    localparam int unsigned CW_TOP = WORD_W + SYN_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } codeword_t;

    // Codeword position (1-based) of data bit idx: the idx-th non-power-of-two slot.
    function automatic int unsigned data_pos(input int unsigned idx);
        int unsigned k;
        int unsigned r;
        k = 0;
        r = 0;
        for (int unsigned p = 1; p <= CW_TOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k == idx) r = p;
                k++;
            end
        end
        return r;
    endfunction

    // Data bits covered by syndrome bit j.
    function automatic logic [WORD_W-1:0] col_mask(input int unsigned j);
        logic [WORD_W-1:0] m;
        int unsigned       p;
        m = '0;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            p    = data_pos(i);
            m[i] = p[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import msgram_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [SYN_W-1:0] syn;

    for (genvar j = 0; j < SYN_W; j++) begin : g_col
        localparam logic [WORD_W-1:0] MASK = col_mask(j);
        assign syn[j] = ^(data_i & MASK);
    end

    assign chk_o = {(^data_i) ^ (^syn), syn};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import msgram_pkg::*;
(
    input  codeword_t         cw_i,
    output logic [WORD_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    localparam logic [SYN_W-1:0] SYN_MAX = SYN_W'(CW_TOP);

    logic [SYN_W-1:0] syn;
    logic             odd;
    logic             in_range;

    for (genvar j = 0; j < SYN_W; j++) begin : g_syn
        localparam logic [WORD_W-1:0] MASK = col_mask(j);
        assign syn[j] = cw_i.chk[j] ^ (^(cw_i.data & MASK));
    end

    assign odd      = (^cw_i.data) ^ (^cw_i.chk);
    assign in_range = (syn <= SYN_MAX);
    assign single_o = odd & in_range;
    assign double_o = (~odd & (|syn)) | (odd & ~in_range);

    for (genvar i = 0; i < WORD_W; i++) begin : g_fix
        localparam logic [SYN_W-1:0] POS = SYN_W'(data_pos(i));
        assign data_o[i] = cw_i.data[i] ^ (single_o & (syn == POS));
    end

endmodule

// File: rtl/msgram_store.sv
module msgram_store
    import msgram_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [AW-1:0] addr_i,
    input  codeword_t     wcw_i,
    output codeword_t     rcw_o
);

    codeword_t mem_q [DEPTH];
    codeword_t rcw_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wcw_i;
        if (re_i) rcw_q <= mem_q[addr_i];
    end

    assign rcw_o = rcw_q;

endmodule

// File: rtl/msgram_secded.sv
module msgram_secded
    import msgram_pkg::*;
#(
    parameter int unsigned DEPTH_WORDS = 512,
    parameter int unsigned ERR_ADDR_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [$clog2(DEPTH_WORDS)-1:0] req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [CHK_W-1:0]      parity_in,
    input  logic                  ecc_en,
    input  logic                  sec_ie,
    input  logic                  ded_ie,
    input  logic [1:0]            flag_clr,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  sec_flag,
    output logic                  ded_flag,
    output logic [ERR_ADDR_W-1:0] err_addr,
    output logic                  irq
);

    localparam int unsigned AW = $clog2(DEPTH_WORDS);

    typedef struct packed {
        logic                  rd_pend;
        logic                  rd_ecc;
        logic [AW-1:0]         rd_addr;
        logic                  sec;
        logic                  ded;
        logic [ERR_ADDR_W-1:0] err_addr;
    } state_t;

    state_t state_d, state_q;

    logic              rd_req;
    logic              wr_req;
    logic [CHK_W-1:0]  enc_chk;
    codeword_t         wr_cw;
    codeword_t         rd_cw;
    logic [WORD_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic              sec_evt;
    logic              ded_evt;

    assign rd_req = req_valid & ~req_write;
    assign wr_req = req_valid &  req_write;

    secded_enc u_enc (
        .data_i (req_wdata),
        .chk_o  (enc_chk)
    );

    assign wr_cw.data = req_wdata;
    assign wr_cw.chk  = ecc_en ? enc_chk : parity_in;

    msgram_store #(
        .DEPTH (DEPTH_WORDS),
        .AW    (AW)
    ) u_store (
        .clk    (clk),
        .we_i   (wr_req),
        .re_i   (rd_req),
        .addr_i (req_addr),
        .wcw_i  (wr_cw),
        .rcw_o  (rd_cw)
    );

    secded_dec u_dec (
        .cw_i     (rd_cw),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    assign sec_evt = state_q.rd_pend & state_q.rd_ecc & dec_single;
    assign ded_evt = state_q.rd_pend & state_q.rd_ecc & dec_double;

    always_comb begin
        state_d         = state_q;
        state_d.rd_pend = rd_req;
        if (rd_req) begin
            state_d.rd_ecc  = ecc_en;
            state_d.rd_addr = req_addr;
        end
        state_d.sec = sec_evt | (state_q.sec & ~flag_clr[0]);
        state_d.ded = ded_evt | (state_q.ded & ~flag_clr[1]);
        if (sec_evt | ded_evt) begin
            state_d.err_addr = ERR_ADDR_W'({state_q.rd_addr, 2'b00});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_valid = state_q.rd_pend;
    assign rd_data  = state_q.rd_ecc ? dec_data : rd_cw.data;
    assign sec_flag = state_q.sec;
    assign ded_flag = state_q.ded;
    assign err_addr = state_q.err_addr;
    assign irq      = (state_q.sec & sec_ie) | (state_q.ded & ded_ie);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_write_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid);

    p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !(sec_evt && ded_evt));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(err_addr));

    p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !state_q.rd_ecc) |=> (!$rose(sec_flag) && !$rose(ded_flag)));

    p_sec_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_flag && !flag_clr[0]) |=> sec_flag);

    p_ded_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_flag && !flag_clr[1]) |=> ded_flag);

endmodule

// File: tb/test_msgram_secded.sv
module test_msgram_secded;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [8:0]  req_addr;
    logic [31:0] req_wdata;
    logic [6:0]  parity_in;
    logic        ecc_en, sec_ie, ded_ie;
    logic [1:0]  flag_clr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sec_flag, ded_flag;
    logic [11:0] err_addr;
    logic        irq;

    always #4 clk = ~clk;

    msgram_secded i_msgram_secded (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .parity_in(parity_in),
        .ecc_en(ecc_en), .sec_ie(sec_ie), .ded_ie(ded_ie), .flag_clr(flag_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .sec_flag(sec_flag),
        .ded_flag(ded_flag), .err_addr(err_addr), .irq(irq)
    );

    int    vecs = 0;
    int    miss = 0;
    string cur_req = "R11";

    logic [31:0] mdat [int];
    logic [6:0]  mchk [int];
    bit          m_rdv, m_esec, m_eded, m_sec, m_ded;
    logic [31:0] m_rdata;
    int          m_pa, m_eaddr;

    function automatic logic [6:0] ref_enc(logic [31:0] d);
        int s = 0;
        int k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) s = s ^ p;
                k++;
            end
        end
        return {(^d) ^ (^s[5:0]), s[5:0]};
    endfunction

    task automatic model_edge();
        bit          nsec, nded;
        logic [31:0] d;
        logic [6:0]  c, e;
        int          s, k;
        bit          odd;
        nsec = (m_rdv && m_esec) || (m_sec && !flag_clr[0]);
        nded = (m_rdv && m_eded) || (m_ded && !flag_clr[1]);
        if (m_rdv && (m_esec || m_eded)) m_eaddr = (m_pa * 4) % 4096;
        m_sec = nsec;
        m_ded = nded;
        m_rdv = 0; m_esec = 0; m_eded = 0;
        if (req_valid && !req_write) begin
            m_rdv = 1;
            m_pa  = int'(req_addr);
            d = mdat[m_pa];
            c = mchk[m_pa];
            m_rdata = d;
            if (ecc_en) begin
                e   = ref_enc(d);
                s   = int'(e[5:0] ^ c[5:0]);
                odd = (^d) ^ (^c);
                if (odd && s <= 38) begin
                    m_esec = 1;
                    k = 0;
                    for (int p = 1; p <= 38; p++) begin
                        if ((p & (p - 1)) != 0) begin
                            if (p == s) m_rdata[k] = ~m_rdata[k];
                            k++;
                        end
                    end
                end else if (odd || s != 0) begin
                    m_eded = 1;
                end
            end
        end
        if (req_valid && req_write) begin
            mdat[int'(req_addr)] = req_wdata;
            mchk[int'(req_addr)] = ecc_en ? ref_enc(req_wdata) : parity_in;
        end
    endtask

    task automatic compare();
        bit exp_irq;
        exp_irq = (m_sec && sec_ie) || (m_ded && ded_ie);
        vecs++;
        if (rd_valid !== m_rdv || (m_rdv && rd_data !== m_rdata) ||
            sec_flag !== m_sec || ded_flag !== m_ded ||
            err_addr !== 12'(m_eaddr) || irq !== exp_irq) begin
            miss++;
            $display("FAIL %s: act rdv=%0b data=%h sec=%0b ded=%0b ea=%h irq=%0b exp rdv=%0b data=%h sec=%0b ded=%0b ea=%h irq=%0b",
                     cur_req, rd_valid, rd_data, sec_flag, ded_flag, err_addr, irq,
                     m_rdv, m_rdata, m_sec, m_ded, 12'(m_eaddr), exp_irq);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int a, logic [31:0] d, bit ecc, logic [6:0] par);
        req_valid = 1; req_write = 1; req_addr = 9'(a);
        req_wdata = d; ecc_en = ecc; parity_in = par;
        cyc();
        req_valid = 0;
    endtask

    task automatic rd(int a, bit ecc);
        req_valid = 1; req_write = 0; req_addr = 9'(a); ecc_en = ecc;
        cyc();
        req_valid = 0;
    endtask

    task automatic clr(logic [1:0] m);
        flag_clr = m;
        cyc();
        flag_clr = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        parity_in = 0; ecc_en = 1; sec_ie = 0; ded_ie = 0; flag_clr = 0;
        m_rdv = 0; m_esec = 0; m_eded = 0; m_sec = 0; m_ded = 0; m_pa = 0; m_eaddr = 0;
        m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_req = "R11"; idle(2);

        cur_req = "R2";
        wr(0, 32'hDEADBEEF, 1, 7'h0);
        wr(1, 32'h00000000, 1, 7'h0);
        wr(5, 32'hFFFFFFFF, 1, 7'h0);
        wr(511, 32'h12345678, 1, 7'h0);
        cur_req = "R1";
        rd(0, 1); rd(1, 1); idle(1); rd(5, 1); rd(511, 1); idle(1);
        wr(2, 32'hA5A5A5A5, 1, 7'h0); idle(1);

        cur_req = "R4";
        sec_ie = 1;
        for (int b = 0; b < 32; b++) begin
            d = 32'h13579BDF ^ (32'(b) << 8);
            wr(10 + b, d ^ (32'h1 << b), 0, ref_enc(d));
            rd(10 + b, 1);
            idle(1);
            clr(2'b01);
        end
        cur_req = "R3";
        for (int i = 0; i < 24; i++) begin
            d = $urandom;
            wr(100 + i, d, 1, 7'h0);
            rd(100 + i, 1);
        end
        idle(1);
        cur_req = "R4";
        rd(10, 0); idle(1);

        cur_req = "R5";
        for (int j = 0; j < 7; j++) begin
            d = 32'hCAFE0000 | 32'(j);
            wr(60 + j, d, 0, ref_enc(d) ^ (7'h1 << j));
            rd(60 + j, 1);
            idle(1);
            clr(2'b01);
        end

        cur_req = "R6";
        ded_ie = 1;
        for (int b = 0; b < 31; b += 3) begin
            d = 32'h0F0F0F0F;
            wr(200 + b, d ^ (32'h3 << b), 0, ref_enc(d));
            rd(200 + b, 1);
            idle(1);
            clr(2'b10);
        end
        wr(250, 32'h55, 0, ref_enc(32'h55) ^ 7'h41);
        rd(250, 1); idle(1);

        cur_req = "R7";
        d = 32'h87654321;
        wr(511, d ^ 32'h80, 0, ref_enc(d));
        rd(511, 1); idle(2);
        wr(3, d ^ 32'h3, 0, ref_enc(d));
        rd(3, 1); idle(2);
        clr(2'b11);

        cur_req = "R8";
        rd(511, 0); idle(1);
        rd(3, 0); idle(1);
        wr(300, 32'h11112222, 0, 7'h5A);
        rd(300, 0); idle(1);
        rd(300, 1); idle(1);
        clr(2'b11);

        cur_req = "R9";
        rd(10, 1);
        clr(2'b01);
        idle(3);
        clr(2'b10);
        idle(1);
        clr(2'b01);
        rd(3, 1);
        clr(2'b10);
        idle(2);

        cur_req = "R10";
        rd(10, 1); idle(1);
        sec_ie = 0; ded_ie = 0; idle(1);
        sec_ie = 1; idle(1);
        sec_ie = 0; ded_ie = 1; idle(1);
        clr(2'b10); idle(1);
        ded_ie = 0; sec_ie = 1; idle(1);
        clr(2'b01); idle(1);

        finish_run();
    end

endmodule